// File: doc/BRIEF.md
# CAN Receive Buffer Acceptance Filter

This block chooses the receive message buffer that stores an incoming CAN frame. A frame has already been parsed when it arrives: its identifier, the identifier-extension flag, the RTR/SRR bit and, for extended frames, the XRTR bit. The block packs these fields into the same two 16-bit words that each buffer holds. It then compares the frame with every buffer at once. Each mask bit that is set turns its bit position into a don't-care.

There are 15 buffers by default. All buffers except the last share one mask pair, called the shared mask. The last buffer has its own mask pair, the catch-all mask. If the catch-all mask is all ones, the last buffer accepts every frame that no other buffer takes. Only buffers in a receive state take part. When several buffers match, the one with the lowest index wins. The result is registered and reported one clock after the frame strobe as a hit flag, a binary index and a one-hot vector.

Top module: `can_acc_filter`

## Requirements
- R1: While reset is asserted and after it is released with no frame presented, res_vld, res_hit, res_idx and res_onehot are all zero.
- R2: A result is presented one clock after the frame strobe. res_vld equals frm_vld delayed by one clock. In a cycle without a strobe, res_hit, res_idx and res_onehot are zero.
- R3: The frame's base word is built as follows. Bits 15:5 carry the 11-bit identifier field. For a standard frame this is frm_id[10:0]; for an extended frame it is frm_id[28:18]. Bit 4 is frm_rtr (RTR or SRR), bit 3 is frm_ide, and bits 2:0 are frm_id[17:15] for an extended frame. A buffer's base word must equal this word on every bit whose mask bit is clear.
- R4: The frame's extension word is {frm_id[14:0], frm_xrtr}, with XRTR in bit 0. It is compared only for extended frames. For a standard frame, the buffer's extension word, its base bits 2:0 and frm_xrtr have no effect on acceptance.
- R5: A mask bit of 1 means don't care and a mask bit of 0 means the bit must match. Buffers 0 to NUM_BUF-2 use the shared mask pair (gmsk_base, gmsk_ext). An all-zero mask requires an exact match.
- R6: The last buffer uses only the catch-all mask pair (bmsk_base, bmsk_ext). The shared mask has no effect on it, and the catch-all mask has no effect on any other buffer.
- R7: Only buffers whose 4-bit state is 4'b0010 (ready) or 4'b0100 (full) may match. Any other state code excludes the buffer.
- R8: If several eligible buffers match, the lowest index wins. res_idx gives that index in binary, and res_onehot has exactly that bit set.
- R9: If a frame matches no eligible buffer, res_vld is 1 while res_hit, res_idx and res_onehot are zero.
- R10: With the catch-all mask all ones, an eligible last buffer accepts every frame not taken by a lower buffer, whatever its ID words hold.
- R11: A buffer that holds the ID of a remote frame sent earlier (RTR or XRTR set) accepts the data reply (RTR and XRTR clear) when only bit 4 of the base mask and bit 0 of the extension mask are set. With a zero mask it rejects that reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | Strobe: the frame fields are valid this cycle |
| frm_ide | input | 1 | Identifier extension: 1 = extended frame |
| frm_rtr | input | 1 | RTR bit (standard frame) or SRR bit (extended frame) |
| frm_xrtr | input | 1 | Remote bit of an extended frame |
| frm_id | input | 29 | Identifier; a standard frame uses bits 10:0 |
| buf_base | input | NUM_BUF*16 | Base ID words; buffer i at [16i+15:16i] |
| buf_ext | input | NUM_BUF*16 | Extension ID words; buffer i at [16i+15:16i] |
| buf_state | input | NUM_BUF*4 | Buffer state codes; buffer i at [4i+3:4i] |
| gmsk_base | input | 16 | Shared base mask |
| gmsk_ext | input | 16 | Shared extension mask |
| bmsk_base | input | 16 | Catch-all base mask |
| bmsk_ext | input | 16 | Catch-all extension mask |
| res_vld | output | 1 | A result is present |
| res_hit | output | 1 | Some buffer accepted the frame |
| res_idx | output | IDX_W | Index of the winning buffer |
| res_onehot | output | NUM_BUF | One-hot winning buffer |

## Verification
The bench targets the four bits that change meaning with the frame format. A filter that compared the extension word or base bits 2:0 on standard frames would reject frames that should be taken. A filter that let the shared mask reach the last buffer would make that buffer a catch-all when it should not be one. Priority is tested with two or more matching buffers and with the lowest of them made ineligible. A wrong encoder would report a higher buffer or set several one-hot bits. The remote-reply masking case and random frames against partly copied buffer IDs test the per-bit don't-care logic. In these cases a swapped field position shows up as a miss or as a spurious hit.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

  localparam int WORD_W  = 16;
  localparam int ID_W    = 29;
  localparam int STATE_W = 4;

  localparam logic [STATE_W-1:0] ST_RX_READY = 4'b0010;
  localparam logic [STATE_W-1:0] ST_RX_FULL  = 4'b0100;

  typedef struct packed {
    logic              ide;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] ext;
  } frame_words_t;

  // Build the two comparison words from the parsed frame fields.
  function automatic frame_words_t pack_frame(input logic ide, input logic rtr,
                                              input logic xrtr, input logic [ID_W-1:0] id);
    frame_words_t fw;
    fw.ide = ide;
    if (ide) begin
      fw.base = {id[28:18], rtr, 1'b1, id[17:15]};
    end else begin
      fw.base = {id[10:0], rtr, 1'b0, 3'b000};
    end
    fw.ext = {id[14:0], xrtr};
    return fw;
  endfunction

  // Base word bits that take part in the comparison for a given format.
  function automatic logic [WORD_W-1:0] base_care(input logic ide);
    return ide ? {WORD_W{1'b1}} : {{(WORD_W-3){1'b1}}, 3'b000};
  endfunction

  // One bit per position that differs and is not masked off.
  function automatic logic [WORD_W-1:0] base_diff(input frame_words_t fw,
                                                  input logic [WORD_W-1:0] bw,
                                                  input logic [WORD_W-1:0] msk);
    return (fw.base ^ bw) & ~msk & base_care(fw.ide);
  endfunction

  function automatic logic [WORD_W-1:0] ext_diff(input frame_words_t fw,
                                                 input logic [WORD_W-1:0] ew,
                                                 input logic [WORD_W-1:0] msk);
    return fw.ide ? ((fw.ext ^ ew) & ~msk) : '0;
  endfunction

  function automatic logic state_ok(input logic [STATE_W-1:0] st);
    return (st == ST_RX_READY) || (st == ST_RX_FULL);
  endfunction

endpackage

// File: rtl/can_flt_cmp.sv
module can_flt_cmp
  import can_flt_pkg::*;
(
  input  frame_words_t        fw,
  input  logic [WORD_W-1:0]   bw_base,
  input  logic [WORD_W-1:0]   bw_ext,
  input  logic [STATE_W-1:0]  bstate,
  input  logic [WORD_W-1:0]   msk_base,
  input  logic [WORD_W-1:0]   msk_ext,
  output logic                id_match,
  output logic                eligible
);

  logic [WORD_W-1:0] d_base;
  logic [WORD_W-1:0] d_ext;

  always_comb begin
    d_base   = base_diff(fw, bw_base, msk_base);
    d_ext    = ext_diff(fw, bw_ext, msk_ext);
    id_match = (d_base == '0) && (d_ext == '0);
    eligible = state_ok(bstate);
  end

endmodule

// File: rtl/can_flt_pick.sv
module can_flt_pick #(
  parameter int N     = 15,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    onehot = cand & ~(cand - N'(1));
    any    = |cand;
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
  import can_flt_pkg::*;
#(
  parameter int NUM_BUF = 15,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frm_vld,
  input  logic                         frm_ide,
  input  logic                         frm_rtr,
  input  logic                         frm_xrtr,
  input  logic [28:0]                  frm_id,
  input  logic [NUM_BUF*16-1:0]        buf_base,
  input  logic [NUM_BUF*16-1:0]        buf_ext,
  input  logic [NUM_BUF*4-1:0]         buf_state,
  input  logic [15:0]                  gmsk_base,
  input  logic [15:0]                  gmsk_ext,
  input  logic [15:0]                  bmsk_base,
  input  logic [15:0]                  bmsk_ext,
  output logic                         res_vld,
  output logic                         res_hit,
  output logic [IDX_W-1:0]             res_idx,
  output logic [NUM_BUF-1:0]           res_onehot
);

  localparam int LAST = NUM_BUF - 1;

  frame_words_t       fw;
  logic [NUM_BUF-1:0] buf_match;
  logic [NUM_BUF-1:0] buf_elig;
  logic [NUM_BUF-1:0] cand;       // eligible and matching, before priority
  logic [NUM_BUF-1:0] win_oh;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;

  always_comb fw = pack_frame(frm_ide, frm_rtr, frm_xrtr, frm_id);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic [WORD_W-1:0] mb;
    logic [WORD_W-1:0] me;
    if (i == LAST) begin : g_catchall
      always_comb begin
        mb = bmsk_base;
        me = bmsk_ext;
      end
    end else begin : g_shared
      always_comb begin
        mb = gmsk_base;
        me = gmsk_ext;
      end
    end
    can_flt_cmp u_cmp (
      .fw       (fw),
      .bw_base  (buf_base[i*WORD_W +: WORD_W]),
      .bw_ext   (buf_ext[i*WORD_W +: WORD_W]),
      .bstate   (buf_state[i*STATE_W +: STATE_W]),
      .msk_base (mb),
      .msk_ext  (me),
      .id_match (buf_match[i]),
      .eligible (buf_elig[i])
    );
  end

  assign cand = buf_match & buf_elig;

  can_flt_pick #(.N(NUM_BUF), .IDX_W(IDX_W)) u_pick (
    .cand   (cand),
    .onehot (win_oh),
    .idx    (win_idx),
    .any    (win_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      res_hit    <= 1'b0;
      res_idx    <= '0;
      res_onehot <= '0;
    end else begin
      res_vld    <= frm_vld;
      res_hit    <= frm_vld & win_any;
      res_idx    <= frm_vld ? win_idx : '0;
      res_onehot <= frm_vld ? win_oh : '0;
    end
  end

endmodule

// File: rtl/can_acc_filter_chk.sv
module can_acc_filter_chk #(
  parameter int NUM_BUF = 15,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frm_vld,
  input logic [NUM_BUF-1:0] cand,
  input logic               res_vld,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_idx,
  input logic [NUM_BUF-1:0] res_onehot
);

  // R2
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> res_vld);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> (!res_vld && !res_hit && res_onehot == '0));

  // R8
  single_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_onehot));

  // R8
  idx_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_onehot[res_idx]);

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && cand[0]) |=> (res_hit && res_idx == '0));

  // R9
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && cand == '0) |=> (res_vld && !res_hit && res_idx == '0 && res_onehot == '0));

endmodule

bind can_acc_filter can_acc_filter_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_vld    (frm_vld),
  .cand       (cand),
  .res_vld    (res_vld),
  .res_hit    (res_hit),
  .res_idx    (res_idx),
  .res_onehot (res_onehot)
);

// File: tb/can_acc_filter_bench.sv
module can_acc_filter_bench;

  localparam int NB = 15;
  localparam int IW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        frm_vld, frm_ide, frm_rtr, frm_xrtr;
  logic [28:0] frm_id;
  logic [15:0] bb [NB];
  logic [15:0] be [NB];
  logic [3:0]  st [NB];
  logic [15:0] gm_b, gm_e, bm_b, bm_e;
  logic [NB*16-1:0] buf_base, buf_ext;
  logic [NB*4-1:0]  buf_state;
  logic          res_vld, res_hit;
  logic [IW-1:0] res_idx;
  logic [NB-1:0] res_onehot;

  int nvec = 0;
  int nbad = 0;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      buf_base[i*16 +: 16] = bb[i];
      buf_ext[i*16 +: 16]  = be[i];
      buf_state[i*4 +: 4]  = st[i];
    end
  end

  can_acc_filter #(.NUM_BUF(NB)) u_can_acc_filter (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .frm_xrtr(frm_xrtr), .frm_id(frm_id),
    .buf_base(buf_base), .buf_ext(buf_ext), .buf_state(buf_state),
    .gmsk_base(gm_b), .gmsk_ext(gm_e), .bmsk_base(bm_b), .bmsk_ext(bm_e),
    .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx), .res_onehot(res_onehot)
  );

  function automatic logic [15:0] mk_base(logic ide, logic rtr, logic [28:0] id);
    return ide ? {id[28:18], rtr, 1'b1, id[17:15]} : {id[10:0], rtr, 1'b0, 3'b000};
  endfunction

  function automatic logic [15:0] mk_ext(logic [28:0] id, logic xr);
    return {id[14:0], xr};
  endfunction

  // Reference model: field-by-field walk, first eligible buffer that fits.
  function automatic int ref_pick();
    for (int b = 0; b < NB; b++) begin
      logic [15:0] mb, me;
      logic [10:0] fidf;
      bit ok;
      if (!(st[b] == 4'd2 || st[b] == 4'd4)) continue;
      mb = (b == NB - 1) ? bm_b : gm_b;
      me = (b == NB - 1) ? bm_e : gm_e;
      fidf = frm_ide ? frm_id[28:18] : frm_id[10:0];
      ok = 1;
      for (int k = 0; k < 11; k++)
        if (!mb[5+k] && bb[b][5+k] !== fidf[k]) ok = 0;
      if (!mb[4] && bb[b][4] !== frm_rtr) ok = 0;
      if (!mb[3] && bb[b][3] !== frm_ide) ok = 0;
      if (frm_ide) begin
        for (int k = 0; k < 3; k++)
          if (!mb[k] && bb[b][k] !== frm_id[15+k]) ok = 0;
        for (int k = 0; k < 15; k++)
          if (!me[1+k] && be[b][1+k] !== frm_id[k]) ok = 0;
        if (!me[0] && be[b][0] !== frm_xrtr) ok = 0;
      end
      if (ok) return b;
    end
    return -1;
  endfunction

  task automatic step(string req);
    int p;
    logic          ev, eh;
    logic [IW-1:0] ei;
    logic [NB-1:0] eo;
    p  = frm_vld ? ref_pick() : -1;
    ev = frm_vld;
    eh = (p >= 0);
    ei = (p >= 0) ? IW'(p) : '0;
    eo = (p >= 0) ? (NB'(1) << p) : '0;
    @(posedge clk);
    #2;
    nvec++;
    if (res_vld !== ev || res_hit !== eh || res_idx !== ei || res_onehot !== eo) begin
      nbad++;
      $display("FAIL %s: got vld=%b hit=%b idx=%0d oh=%h, expected vld=%b hit=%b idx=%0d oh=%h",
               req, res_vld, res_hit, res_idx, res_onehot, ev, eh, ei, eo);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < NB; i++) begin
      bb[i] = 16'h0; be[i] = 16'h0; st[i] = 4'd0;
    end
    gm_b = 0; gm_e = 0; bm_b = 0; bm_e = 0;
  endtask

  task automatic frame(logic ide, logic rtr, logic xr, logic [28:0] id);
    frm_vld = 1; frm_ide = ide; frm_rtr = rtr; frm_xrtr = xr; frm_id = id;
  endtask

  task automatic load(int b, logic ide, logic rtr, logic xr, logic [28:0] id, logic [3:0] s);
    bb[b] = mk_base(ide, rtr, id); be[b] = mk_ext(id, xr); st[b] = s;
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: got no end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    clr();
    frm_vld = 0; frm_ide = 0; frm_rtr = 0; frm_xrtr = 0; frm_id = 0;
    repeat (3) @(posedge clk);
    #2;
    nvec++;
    // R1 reset state
    if (res_vld !== 0 || res_hit !== 0 || res_idx !== 0 || res_onehot !== 0) begin
      nbad++;
      $display("FAIL R1: got vld=%b hit=%b idx=%0d oh=%h, expected all zero",
               res_vld, res_hit, res_idx, res_onehot);
    end
    rst_n = 1;
    step("R1 idle after reset");

    // R3 standard exact match
    load(5, 0, 0, 0, 29'h123, 4'd2);
    frame(0, 0, 0, 29'h123); step("R3 standard exact");
    // R8 priority between two
    load(3, 0, 0, 0, 29'h123, 4'd2);
    step("R8 lowest index wins");
    load(9, 0, 0, 0, 29'h123, 4'd4);
    step("R8 three matches");
    // R7 eligibility codes
    st[3] = 4'd0;  step("R7 inactive excluded");
    st[3] = 4'd4;  step("R7 full eligible");
    st[3] = 4'd6;  step("R7 overrun excluded");
    st[3] = 4'd8;  step("R7 tx code excluded");
    // R2 back-to-back then idle
    frame(0, 0, 0, 29'h124); step("R2 back-to-back miss R9");
    frm_vld = 0; step("R2 idle after frame");
    // R4 standard ignores ext word and low base bits
    clr();
    load(6, 0, 0, 0, 29'h055, 4'd2);
    be[6] = 16'hBEEF; bb[6][2:0] = 3'b101;
    frame(0, 0, 1, 29'h1FFFF855); step("R4 standard ignores ext");
    frame(0, 1, 0, 29'h055); step("R3 rtr bit compared");
    // R4 extended
    clr();
    load(2, 1, 1, 0, 29'h1ABCDEF3, 4'd2);
    frame(1, 1, 0, 29'h1ABCDEF3); step("R4 extended exact");
    frame(1, 1, 0, 29'h1ABCDEF2); step("R4 ext id bit0 differs R9");
    frame(1, 1, 1, 29'h1ABCDEF3); step("R4 xrtr differs");
    frame(1, 1, 0, 29'h1ABCDEF3 ^ 29'h8000); step("R3 id bit15 differs");
    frame(0, 1, 0, 29'h1ABCDEF3); step("R3 ide differs");
    // R5 shared mask
    gm_e = 16'h0002;
    frame(1, 1, 0, 29'h1ABCDEF2); step("R5 masked ext bit");
    gm_e = 0; gm_b = 16'h0001;
    frame(1, 1, 0, 29'h1ABCDEF3 ^ 29'h8000); step("R5 masked base bit");
    // R6 mask domains
    clr();
    load(14, 0, 0, 0, 29'h700, 4'd2);
    frame(0, 0, 0, 29'h700); step("R6 last buffer exact");
    gm_b = 16'hFFFF; gm_e = 16'hFFFF;
    frame(0, 0, 0, 29'h701); step("R6 shared mask not on last");
    bm_b = 16'hFFFF; bm_e = 16'hFFFF;
    frame(1, 1, 1, 29'h0F0F0F0F); step("R10 catch-all any frame");
    gm_b = 0; gm_e = 0;
    load(7, 0, 0, 0, 29'h321, 4'd2);
    frame(0, 0, 0, 29'h322); step("R6 basic mask not on others R10");
    frame(0, 0, 0, 29'h321); step("R10 lower buffer first");
    st[14] = 4'd0;
    frame(0, 0, 0, 29'h111); step("R10 ineligible catch-all");
    // R11 remote reply
    clr();
    load(4, 0, 1, 0, 29'h2A5, 4'd2);
    frame(0, 0, 0, 29'h2A5); step("R11 reply rejected zero mask");
    gm_b = 16'h0010; gm_e = 16'h0001;
    step("R11 standard reply accepted");
    load(4, 1, 1, 1, 29'h0BADF00D, 4'd2);
    frame(1, 1, 0, 29'h0BADF00D); step("R11 extended reply accepted");
    gm_b = 0; gm_e = 0;
    step("R11 extended reply rejected");
    frm_vld = 0; step("R2 idle");

    // random mix: R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 400; n++) begin
      logic ide, rtr, xr;
      logic [28:0] id;
      ide = 1'($urandom); rtr = 1'($urandom); xr = 1'($urandom);
      id = 29'($urandom);
      for (int b = 0; b < NB; b++) begin
        int r;
        r = $urandom % 4;
        st[b] = 4'(2 * ($urandom % 4));
        if (r == 0) load(b, ide, rtr, xr, id, st[b]);
        else if (r == 1) begin
          load(b, ide, rtr, xr, id, st[b]);
          bb[b][$urandom % 16] ^= 1'b1;
        end else if (r == 2) begin
          load(b, ide, rtr, xr, id, st[b]);
          be[b][$urandom % 16] ^= 1'b1;
        end else begin
          bb[b] = 16'($urandom); be[b] = 16'($urandom);
        end
      end
      gm_b = ($urandom % 3 == 0) ? 16'($urandom) : 16'h0;
      gm_e = ($urandom % 3 == 0) ? 16'($urandom) : 16'h0;
      bm_b = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom & $urandom);
      bm_e = ($urandom % 4 == 0) ? 16'hFFFF : 16'h0;
      frm_vld = ($urandom % 8 != 0);
      frm_ide = ide; frm_rtr = rtr; frm_xrtr = xr; frm_id = id;
      step("R8 random R5 R6 R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule